// File: doc/BRIEF.md
# Dual Panel Line Splitter

The block sits between a display controller and two identical parallel RGB panels. The controller is set up to scan one frame that is twice as tall as a single panel. The default is 800 pixels by 960 lines, and each panel has 480 lines. The splitter counts lines and sends the horizontal sync of the upper half of that frame to panel A and of the lower half to panel B. The idle panel therefore never sees a line start. Software draws the upper half of its frame buffer for panel A and the lower half for panel B. Apart from that split, the tall frame is an ordinary frame buffer.

All logic runs on the pixel clock. Three things are shared by both panels: the pixel data bus, the pixel clock and vertical sync. Each panel gets its own horizontal sync and its own data enable. Both are qualified by the same per-line choice of panel, so a panel never latches pixels that belong to the other one. Every output is registered, and all of them lag the inputs by one pixel clock. This keeps data, enables and syncs aligned with each other.

Top module: `dual_panel_splitter`

## Requirements
- R1: While `rst` is high, every sync and enable output is 0 and `pix_data` is 0.
- R2: `a_vsync` and `b_vsync` both equal `in_vsync` one clock later.
- R3: `pix_data` equals `in_data` one clock later, whatever the line and the panel selection.
- R4: The line index is cleared while `in_vsync` is high. The first rising edge of `in_hsync` with `in_vsync` low starts line 0, and each later rising edge starts the next line. Rising edges of `in_hsync` while `in_vsync` is high are neither counted nor forwarded.
- R5: The complete `in_hsync` pulse of lines 0 to PANEL_LINES-1 appears on `a_hsync` one clock later, and `b_hsync` stays 0.
- R6: The complete `in_hsync` pulse of lines PANEL_LINES to 2*PANEL_LINES-1 appears on `b_hsync` one clock later, and `a_hsync` stays 0.
- R7: Lines numbered 2*PANEL_LINES or higher reach neither panel. Both horizontal syncs and both enables stay 0 for those lines.
- R8: `a_de` (`b_de`) equals `in_de` one clock later when the current line belongs to panel A (B). Otherwise it is 0. It is also 0 while `in_vsync` is high and before the first line of a frame.
- R9: A frame of exactly 2*PANEL_LINES lines gives PANEL_LINES pulses on `a_hsync` and PANEL_LINES pulses on `b_hsync`.
- R10: A vertical sync in the middle of a frame restarts the count, so the next line goes to panel A as line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_hsync | input | 1 | Host horizontal sync, active high |
| in_vsync | input | 1 | Host vertical sync, active high |
| in_de | input | 1 | Host data enable |
| in_data | input | DATA_W | Host pixel data |
| pix_data | output | DATA_W | Pixel data shared by both panels |
| a_hsync | output | 1 | Horizontal sync to panel A |
| a_vsync | output | 1 | Vertical sync to panel A |
| a_de | output | 1 | Data enable to panel A |
| b_hsync | output | 1 | Horizontal sync to panel B |
| b_vsync | output | 1 | Vertical sync to panel B |
| b_de | output | 1 | Data enable to panel B |

## Verification
The only hidden state is the line index and each panel's latched selection. A wrong value in either shows up at the very next horizontal sync pulse: that pulse and the enable window after it go to the wrong panel or to none. It is visible one clock after the host's rising edge. A counter that steps twice or misses an edge shifts the boundary between the halves, so the per-frame pulse count moves away from PANEL_LINES by the end of the first full frame. A bad clear shows up as misrouted lines right after a restarting vertical sync.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2
  } panel_sel_e;

  // Which panel owns a given line of the tall host frame.
  function automatic panel_sel_e line_to_panel(input int unsigned line,
                                               input int unsigned panel_lines);
    if (line < panel_lines)          return SEL_A;
    else if (line < 2 * panel_lines) return SEL_B;
    else                             return SEL_NONE;
  endfunction

  // Panel identity of generate index 0 / 1.
  function automatic panel_sel_e panel_of_index(input int unsigned idx);
    if (idx == 0) return SEL_A;
    else          return SEL_B;
  endfunction

endpackage

// File: rtl/dps_rise_det.sv
module dps_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  assign rise = sig & ~prev_q;

  // R4: a detected edge is a single-cycle event
  a_r4_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/dps_line_ctr.sv
module dps_line_ctr #(
  parameter int unsigned MAX_LINES = 960,
  parameter int unsigned CNT_W     = $clog2(MAX_LINES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LINES);

  logic at_limit;
  assign at_limit = (count == LIMIT);

  always_ff @(posedge clk) begin
    if (rst)                    count <= '0;
    else if (clear)             count <= '0;
    else if (step && !at_limit) count <= count + CNT_W'(1);
  end

  // R4: vertical sync empties the counter
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0));

  // R4: one line start advances the index by exactly one
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (!clear && step && !at_limit) |=> (count == $past(count) + CNT_W'(1)));

  // R7: beyond the tall frame the index parks at the limit
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (!clear && at_limit) |=> at_limit);

endmodule

// File: rtl/dps_panel_gate.sv
module dps_panel_gate
  import dps_pkg::*;
#(
  parameter panel_sel_e MY_PANEL = SEL_A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vsync,
  input  logic       line_start,
  input  panel_sel_e start_sel,
  input  logic       hsync,
  input  logic       de,
  output logic       hs_o,
  output logic       de_o
);
  logic mine_q;
  logic mine_now;

  // Ownership is decided at the line start and held until the next one.
  always_comb begin
    if (vsync)           mine_now = 1'b0;
    else if (line_start) mine_now = (start_sel == MY_PANEL);
    else                 mine_now = mine_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mine_q <= 1'b0;
      hs_o   <= 1'b0;
      de_o   <= 1'b0;
    end else begin
      mine_q <= mine_now;
      hs_o   <= hsync & mine_now;
      de_o   <= de & mine_now;
    end
  end

  // R5: a forwarded pulse may only begin at a host line start
  a_r5_pulse_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_o) |-> $past(line_start));

  // R8: nothing reaches a panel while vertical sync is active
  a_r8_vsync_blank: assert property (@(posedge clk) disable iff (rst)
    $past(vsync) |-> (!hs_o && !de_o));

endmodule

// File: rtl/dual_panel_splitter.sv
module dual_panel_splitter
  import dps_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned PANEL_LINES = 480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic              in_de,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] pix_data,
  output logic              a_hsync,
  output logic              a_vsync,
  output logic              a_de,
  output logic              b_hsync,
  output logic              b_vsync,
  output logic              b_de
);
  localparam int unsigned FRAME_LINES = 2 * PANEL_LINES;
  localparam int unsigned CNT_W       = $clog2(FRAME_LINES + 1);
  localparam int unsigned N_PANELS    = 2;

  logic             hs_rise;
  logic [CNT_W-1:0] line_idx;
  panel_sel_e       start_sel;
  logic             hs_vec [N_PANELS];
  logic             de_vec [N_PANELS];
  logic             armed_q;

  dps_rise_det u_rise (
    .clk  (clk),
    .rst  (rst),
    .sig  (in_hsync),
    .rise (hs_rise)
  );

  dps_line_ctr #(
    .MAX_LINES (FRAME_LINES),
    .CNT_W     (CNT_W)
  ) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .clear (in_vsync),
    .step  (hs_rise),
    .count (line_idx)
  );

  // Index before increment is the number of the line now starting.
  assign start_sel = line_to_panel(int'(line_idx), PANEL_LINES);

  for (genvar g = 0; g < N_PANELS; g++) begin : g_panel
    dps_panel_gate #(
      .MY_PANEL (panel_of_index(g))
    ) u_gate (
      .clk        (clk),
      .rst        (rst),
      .vsync      (in_vsync),
      .line_start (hs_rise),
      .start_sel  (start_sel),
      .hsync      (in_hsync),
      .de         (in_de),
      .hs_o       (hs_vec[g]),
      .de_o       (de_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_data <= '0;
      a_vsync  <= 1'b0;
      b_vsync  <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      pix_data <= in_data;
      a_vsync  <= in_vsync;
      b_vsync  <= in_vsync;
      armed_q  <= 1'b1;
    end
  end

  assign a_hsync = hs_vec[0];
  assign b_hsync = hs_vec[1];
  assign a_de    = de_vec[0];
  assign b_de    = de_vec[1];

  // R2: vertical sync reaches both panels one clock late
  a_r2_vsync_follow: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (a_vsync == $past(in_vsync) && b_vsync == $past(in_vsync)));

  // R3: pixel data is never gated
  a_r3_data_follow: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (pix_data == $past(in_data)));

  // R5 / R6: a line never reaches both panels
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !((a_hsync && b_hsync) || (a_de && b_de)));

endmodule

// File: tb/dual_panel_splitter_bench.sv
`timescale 1ns/1ps
module dual_panel_splitter_bench;
  localparam int DW = 24;
  localparam int PL = 480;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_hsync = 1'b0, in_vsync = 1'b0, in_de = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] pix_data;
  logic          a_hsync, a_vsync, a_de, b_hsync, b_vsync, b_de;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // expectations for the next sample
  logic          e_ahs = 0, e_bhs = 0, e_ade = 0, e_bde = 0, e_vs = 0;
  logic [DW-1:0] e_data = '0;
  int            cur_sel = 0;       // 0 none, 1 panel A, 2 panel B
  string         cur_tag = "R5";
  logic          prev_a = 0, prev_b = 0;
  int            pulses_a = 0, pulses_b = 0;

  always #2 clk = ~clk;

  dual_panel_splitter #(.DATA_W(DW), .PANEL_LINES(PL)) u_dual_panel_splitter (
    .clk(clk), .rst(rst), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .in_de(in_de), .in_data(in_data), .pix_data(pix_data),
    .a_hsync(a_hsync), .a_vsync(a_vsync), .a_de(a_de),
    .b_hsync(b_hsync), .b_vsync(b_vsync), .b_de(b_de));

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Panel owning a line, derived by integer division of the line number.
  function automatic int owner(input int line);
    int q;
    q = line / PL;
    return (q == 0) ? 1 : (q == 1) ? 2 : 0;
  endfunction

  task automatic step(input logic hs, input logic vs, input logic de, input logic [DW-1:0] d);
    @(negedge clk);
    check(cur_tag, a_hsync, e_ahs);
    check(cur_tag, b_hsync, e_bhs);
    check("R8", a_de, e_ade);
    check("R8", b_de, e_bde);
    check("R2", a_vsync, e_vs);
    check("R2", b_vsync, e_vs);
    check("R3", pix_data, e_data);
    if (a_hsync && !prev_a) pulses_a++;
    if (b_hsync && !prev_b) pulses_b++;
    prev_a = a_hsync;
    prev_b = b_hsync;
    in_hsync = hs; in_vsync = vs; in_de = de; in_data = d;
    e_ahs  = hs && !vs && cur_sel == 1;
    e_bhs  = hs && !vs && cur_sel == 2;
    e_ade  = de && !vs && cur_sel == 1;
    e_bde  = de && !vs && cur_sel == 2;
    e_vs   = vs;
    e_data = d;
  endtask

  // R4: vertical blank, optionally with a stray hsync pulse inside it
  task automatic send_vsync(input bit stray_hs);
    cur_sel = 0;
    cur_tag = "R4";
    for (int i = 0; i < 4; i++) step(stray_hs && (i == 1 || i == 2), 1'b1, 1'b0, DW'(i + 7));
    step(1'b0, 1'b0, 1'b1, DW'(3));   // enable before first line must stay blank (R8)
  endtask

  task automatic send_line(input int line, input string tag);
    cur_sel = owner(line);
    cur_tag = tag;
    step(1'b1, 1'b0, 1'b0, DW'(line * 16));
    step(1'b1, 1'b0, 1'b0, DW'(line * 16 + 1));
    step(1'b0, 1'b0, 1'b0, DW'(line * 16 + 2));
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b1, DW'(line * 16 + 3 + k));
    step(1'b0, 1'b0, 1'b0, DW'(line * 16 + 9));
  endtask

  function automatic string line_tag(input int line);
    int o;
    o = owner(line);
    return (o == 1) ? "R5" : (o == 2) ? "R6" : "R7";
  endfunction

  task automatic count_check(input string tag, input int exp_a, input int exp_b);
    step(1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
    check(tag, DW'(pulses_a), DW'(exp_a));
    check(tag, DW'(pulses_b), DW'(exp_b));
    pulses_a = 0;
    pulses_b = 0;
  endtask

  initial begin
    // R1: reset state, with busy inputs
    in_hsync = 1; in_vsync = 1; in_de = 1; in_data = 24'hABCDEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", a_hsync, 0); check("R1", b_hsync, 0);
    check("R1", a_de, 0);    check("R1", b_de, 0);
    check("R1", a_vsync, 0); check("R1", b_vsync, 0);
    check("R1", pix_data, '0);
    in_hsync = 0; in_vsync = 0; in_de = 0; in_data = '0;
    @(negedge clk);
    rst = 0;
    e_ahs = 0; e_bhs = 0; e_ade = 0; e_bde = 0; e_vs = 0; e_data = '0;

    // R9: full tall frame, split evenly
    send_vsync(1'b0);
    for (int l = 0; l < 2 * PL; l++) send_line(l, line_tag(l));
    count_check("R9", PL, PL);

    // R7: overlong frame; R4: stray hsync during vsync is ignored
    send_vsync(1'b1);
    for (int l = 0; l < 2 * PL + 10; l++) send_line(l, line_tag(l));
    count_check("R7", PL, PL);

    // R10: frame cut short by vsync, then a complete frame
    send_vsync(1'b0);
    for (int l = 0; l < 100; l++) send_line(l, "R10");
    send_vsync(1'b0);
    for (int l = 0; l < 2 * PL; l++) send_line(l, (l < 3) ? "R10" : line_tag(l));
    count_check("R10", 100 + PL, PL);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule